// File: doc/BRIEF.md
# Column-order long integer multiplier

This block forms the full product of two unsigned long integers, each held as an array of 16-bit digits in its own operand memory. The digit products are generated in product-scanning order. For result column k, every pair of digit indices i and j with i + j = k is read and multiplied by a single 16x16 unsigned multiplier. The products are added into a wide accumulator. When a column closes, its low digit goes to the result memory and the accumulator moves down by one digit. The operand and result memories are separate banks, so reads and writes never compete.

Software or a sequencer writes both operands, sets the operand length n (in digits) and pulses `start`. One multiply-accumulate is issued on every clock, so the run takes n*n issue cycles plus a short pipeline tail. The run writes 2n result digits in ascending address order and then raises `done` for one cycle. The operand memories are assumed to have a synchronous read with one cycle of latency.

Top module: `colmul_top`

## Requirements
- R1: After reset, and while no operation has been started, `r_we` and `done` are 0.
- R2: While an operation runs, each operand read address is below the accepted length n. Columns are visited in ascending order, and each (i, j) pair with i + j = k is issued once within column k.
- R3: Result digit k, for k from 0 to 2n-2, is written once, at result address k, in ascending address order. Its value is the low 16 bits of the sum of all a_i*b_j with i + j = k plus the carry left from column k-1.
- R4: After the last column, the remaining accumulator value is written as digit 2n-1. The 2n digits written, taken least significant first at addresses 0 to 2n-1, equal the exact product A*B.
- R5: The result is exact when every operand digit is 0xFFFF, which is the case with the largest column sums and carries.
- R6: The lengths n = 1 and n = MAX_LEN (default 32) both give the exact product.
- R7: `done` is high for exactly one cycle, and it rises in the cycle after the cycle in which the last result digit (address 2n-1) is presented on the write port.
- R8: `done` is observed after the (n*n + 4)th rising clock edge that follows the edge accepting `start`, which is one multiply-accumulate per clock.
- R9: A `start` pulse during an operation is ignored. The running operation keeps its digits and timing, and no further result writes follow its `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an operation when the block is idle |
| len | input | $clog2(MAX_LEN+1) | Operand length in digits, 1 to MAX_LEN, sampled with start |
| a_addr | output | $clog2(MAX_LEN) | Read address to operand A memory |
| a_rdata | input | DW | Digit of A, valid one cycle after a_addr |
| b_addr | output | $clog2(MAX_LEN) | Read address to operand B memory |
| b_rdata | input | DW | Digit of B, valid one cycle after b_addr |
| r_we | output | 1 | Result memory write enable |
| r_addr | output | $clog2(2*MAX_LEN) | Result memory write address |
| r_wdata | output | DW | Result digit to write |
| done | output | 1 | One-cycle pulse after the final result write |

## Verification
The hardest condition to reach is a wide column that carries heavily into the next: the upper accumulator bits must survive many column shifts and then fit exactly in the final digit. The stimulus reaches it with all-ones operands at the full length of 32 digits, which gives columns of 32 maximal products. Pseudo-random operands and length-1 operands fill in the remaining cases. A second start pulse is injected a few cycles into a run to show that a busy block ignores it. Every clock, each write is compared against an expected digit stream computed by row-order long multiplication.

// File: rtl/colmul_pkg.sv
package colmul_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE,
      SEQ_RUN,
      SEQ_WAIT
   } seq_state_e;

   // travels with each issued digit pair through the datapath
   typedef struct packed {
      logic valid;
      logic col_end;
      logic last_col;
   } mac_tag_t;

endpackage

// File: rtl/colmul_seq.sv
module colmul_seq
   import colmul_pkg::*;
#(
   parameter int MAX_LEN = 32,
   localparam int AW  = $clog2(MAX_LEN),
   localparam int LW  = $clog2(MAX_LEN + 1),
   localparam int RAW = $clog2(2 * MAX_LEN)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [LW-1:0] len,
   input  logic          mac_done,
   output logic [AW-1:0] a_addr,
   output logic [AW-1:0] b_addr,
   output mac_tag_t      tag
);

   seq_state_e    state_q;
   logic [LW-1:0] len_q;
   logic [RAW-1:0] col_q;
   logic [AW-1:0] row_q;
   logic [AW-1:0] row_hi_q;

   logic [RAW:0]  nxt_col;
   logic [RAW:0]  len_x;
   logic [RAW:0]  lo_nxt;
   logic [RAW:0]  hi_nxt;
   logic [RAW-1:0] b_diff;
   logic          col_end;
   logic          last_col;

   always_comb begin
      len_x    = (RAW+1)'(len_q);
      nxt_col  = (RAW+1)'(col_q) + 1'b1;
      lo_nxt   = (nxt_col >= len_x) ? (nxt_col - len_x + 1'b1) : '0;
      hi_nxt   = (nxt_col < len_x) ? nxt_col : (len_x - 1'b1);
      b_diff   = col_q - RAW'(row_q);
      col_end  = (row_q == row_hi_q);
      last_col = ((RAW+1)'(col_q) == ((len_x << 1) - 2'd2));
   end

   assign a_addr       = row_q;
   assign b_addr       = b_diff[AW-1:0];
   assign tag.valid    = (state_q == SEQ_RUN);
   assign tag.col_end  = (state_q == SEQ_RUN) && col_end;
   assign tag.last_col = (state_q == SEQ_RUN) && col_end && last_col;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SEQ_IDLE;
         len_q    <= '0;
         col_q    <= '0;
         row_q    <= '0;
         row_hi_q <= '0;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (start) begin
                  state_q  <= SEQ_RUN;
                  len_q    <= len;
                  col_q    <= '0;
                  row_q    <= '0;
                  row_hi_q <= '0;
               end
            end
            SEQ_RUN: begin
               if (col_end) begin
                  if (last_col) begin
                     state_q <= SEQ_WAIT;
                  end else begin
                     col_q    <= nxt_col[RAW-1:0];
                     row_q    <= lo_nxt[AW-1:0];
                     row_hi_q <= hi_nxt[AW-1:0];
                  end
               end else begin
                  row_q <= row_q + 1'b1;
               end
            end
            SEQ_WAIT: begin
               if (mac_done) state_q <= SEQ_IDLE;
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   // R2: operand addresses stay inside the accepted length
   p_addr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SEQ_RUN) |-> ((LW'(a_addr) < len_q) && (LW'(b_addr) < len_q)));

   // R9: a start while busy does not reload the length
   p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != SEQ_IDLE && start) |=> $stable(len_q));

endmodule

// File: rtl/colmul_mac.sv
module colmul_mac
   import colmul_pkg::*;
#(
   parameter int DW       = 16,
   parameter int ACC_W    = 50,
   parameter int MAX_LEN  = 32,
   parameter bit MUL_PIPE = 1'b1,
   localparam int PW  = 2 * DW,
   localparam int RAW = $clog2(2 * MAX_LEN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  mac_tag_t       tag_in,
   input  logic [DW-1:0]  a_d,
   input  logic [DW-1:0]  b_d,
   output logic           r_we,
   output logic [RAW-1:0] r_addr,
   output logic [DW-1:0]  r_wdata,
   output logic           done
);

   mac_tag_t       tag_rd;
   mac_tag_t       tag_p;
   logic [PW-1:0]  prod_c;
   logic [PW-1:0]  prod_p;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] sum;
   logic [RAW-1:0] wr_cnt_q;
   logic           flush_q;
   logic           last_wr_q;

   // align the tag with the read data of the operand memories
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tag_rd <= '0;
      else        tag_rd <= tag_in;
   end

   assign prod_c = a_d * b_d;

   generate
      if (MUL_PIPE) begin : g_mul_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prod_p <= '0;
               tag_p  <= '0;
            end else begin
               prod_p <= prod_c;
               tag_p  <= tag_rd;
            end
         end
      end else begin : g_mul_comb
         assign prod_p = prod_c;
         assign tag_p  = tag_rd;
      end
   endgenerate

   assign sum = acc_q + ACC_W'(prod_p);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         wr_cnt_q  <= '0;
         flush_q   <= 1'b0;
         last_wr_q <= 1'b0;
         done      <= 1'b0;
         r_we      <= 1'b0;
         r_addr    <= '0;
         r_wdata   <= '0;
      end else begin
         r_we      <= 1'b0;
         last_wr_q <= flush_q;
         done      <= last_wr_q;
         if (flush_q) begin
            r_we     <= 1'b1;
            r_addr   <= wr_cnt_q;
            r_wdata  <= acc_q[DW-1:0];
            acc_q    <= '0;
            wr_cnt_q <= '0;
            flush_q  <= 1'b0;
         end else if (tag_p.valid) begin
            if (tag_p.col_end) begin
               acc_q    <= sum >> DW;
               r_we     <= 1'b1;
               r_addr   <= wr_cnt_q;
               r_wdata  <= sum[DW-1:0];
               wr_cnt_q <= wr_cnt_q + 1'b1;
               flush_q  <= tag_p.last_col;
            end else begin
               acc_q <= sum;
            end
         end
      end
   end

   // R4: what is left after the last column fits in a single digit
   p_flush_fits_r4: assert property (@(posedge clk) disable iff (!rst_n)
      flush_q |-> (acc_q[ACC_W-1:DW] == '0));

   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R7: done follows a result write
   p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(r_we));

endmodule

// File: rtl/colmul_top.sv
module colmul_top
   import colmul_pkg::*;
#(
   parameter int DW       = 16,
   parameter int ACC_W    = 50,
   parameter int MAX_LEN  = 32,
   parameter bit MUL_PIPE = 1'b1,
   localparam int AW  = $clog2(MAX_LEN),
   localparam int LW  = $clog2(MAX_LEN + 1),
   localparam int RAW = $clog2(2 * MAX_LEN)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [LW-1:0]  len,
   output logic [AW-1:0]  a_addr,
   input  logic [DW-1:0]  a_rdata,
   output logic [AW-1:0]  b_addr,
   input  logic [DW-1:0]  b_rdata,
   output logic           r_we,
   output logic [RAW-1:0] r_addr,
   output logic [DW-1:0]  r_wdata,
   output logic           done
);

   generate
      if (MAX_LEN < 2) begin : g_bad_len
         $error("MAX_LEN must be at least 2");
      end
      if (ACC_W < 2 * DW + $clog2(MAX_LEN) + 1) begin : g_bad_acc
         $error("ACC_W too narrow for a full column sum");
      end
   endgenerate

   mac_tag_t tag;

   colmul_seq #(
      .MAX_LEN (MAX_LEN)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len      (len),
      .mac_done (done),
      .a_addr   (a_addr),
      .b_addr   (b_addr),
      .tag      (tag)
   );

   colmul_mac #(
      .DW       (DW),
      .ACC_W    (ACC_W),
      .MAX_LEN  (MAX_LEN),
      .MUL_PIPE (MUL_PIPE)
   ) u_mac (
      .clk     (clk),
      .rst_n   (rst_n),
      .tag_in  (tag),
      .a_d     (a_rdata),
      .b_d     (b_rdata),
      .r_we    (r_we),
      .r_addr  (r_addr),
      .r_wdata (r_wdata),
      .done    (done)
   );

endmodule

// File: tb/tb_colmul_top.sv
module tb_colmul_top;

   localparam int CLK_PERIOD = 10;
   localparam int MAXN = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  len = '0;
   logic [4:0]  a_addr, b_addr;
   logic [15:0] a_rdata, b_rdata;
   logic        r_we;
   logic [5:0]  r_addr;
   logic [15:0] r_wdata;
   logic        done;

   logic [15:0] amem [MAXN];
   logic [15:0] bmem [MAXN];
   longint      expd [2*MAXN];

   int checks = 0;
   int fails  = 0;
   int unsigned seed = 32'h1234_5678;

   always #(CLK_PERIOD/2) clk = ~clk;

   colmul_top dut (
      .clk(clk), .rst_n(rst_n), .start(start), .len(len),
      .a_addr(a_addr), .a_rdata(a_rdata),
      .b_addr(b_addr), .b_rdata(b_rdata),
      .r_we(r_we), .r_addr(r_addr), .r_wdata(r_wdata), .done(done)
   );

   // operand memories with one cycle of read latency
   always_ff @(posedge clk) begin
      a_rdata <= amem[a_addr];
      b_rdata <= bmem[b_addr];
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] next_rand();
      seed = seed * 32'd1103515245 + 32'd12345;
      return seed[23:8];
   endfunction

   // row-order schoolbook product as the reference
   task automatic make_expected(input int n);
      for (int k = 0; k < 2*n; k++) expd[k] = 0;
      for (int i = 0; i < n; i++) begin
         longint carry = 0;
         for (int j = 0; j < n; j++) begin
            longint t = expd[i+j] + longint'(amem[i]) * longint'(bmem[j]) + carry;
            expd[i+j] = t & 64'hFFFF;
            carry = t >> 16;
         end
         expd[i+n] = carry;
      end
   endtask

   task automatic run_op(input int n, input bit mid_start, input string req);
      int  cnt = 0;
      int  widx = 0;
      bit  seen = 1'b0;
      bit  prev_we = 1'b0;
      make_expected(n);
      @(negedge clk);
      len = 6'(n);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      while (!seen && cnt < n*n + 60) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (mid_start) begin
            start = (cnt == 3);
            len = (cnt == 3) ? 6'd3 : 6'(n);
         end
         if (r_we) begin
            check(widx < 2*n, "R3", "write count exceeds 2n", widx, 2*n);
            check(r_addr == 6'(widx), (widx == 2*n-1) ? "R4" : "R3",
                  {req, " result address"}, r_addr, widx);
            check(longint'(r_wdata) == expd[widx], (widx == 2*n-1) ? "R4" : "R3",
                  {req, " result digit"}, r_wdata, expd[widx]);
            widx++;
         end
         if (done) begin
            seen = 1'b1;
            check(widx == 2*n, "R3", {req, " digits written by done"}, widx, 2*n);
            check(cnt == n*n + 4, "R8", {req, " edges to done"}, cnt, n*n + 4);
            check(prev_we && !r_we, "R7", {req, " done one cycle after last write"},
                  {prev_we, r_we}, 2'b10);
         end
         prev_we = r_we;
      end
      start = 1'b0;
      check(seen, "R8", {req, " done never arrived"}, 0, 1);
      @(negedge clk);
      check(!done, "R7", {req, " done longer than one cycle"}, done, 0);
      if (mid_start) begin
         int extra = 0;
         for (int c = 0; c < 25; c++) begin
            @(negedge clk);
            if (r_we || done) extra++;
         end
         check(extra == 0, "R9", "activity after ignored start", extra, 0);
      end
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 190000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < MAXN; i++) begin
         amem[i] = '0;
         bmem[i] = '0;
      end
      repeat (3) @(negedge clk);
      check(!r_we && !done, "R1", "outputs during reset", {r_we, done}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(!r_we && !done, "R1", "outputs idle after reset", {r_we, done}, 0);

      // R6: shortest length, maximal digits
      amem[0] = 16'hFFFF; bmem[0] = 16'hFFFF;
      run_op(1, 1'b0, "R6 n=1 ones");
      amem[0] = 16'h1234; bmem[0] = 16'h0002;
      run_op(1, 1'b0, "R6 n=1 small");

      // R2 / R3: small random operands
      for (int i = 0; i < 2; i++) begin amem[i] = next_rand(); bmem[i] = next_rand(); end
      run_op(2, 1'b0, "R2 n=2 random");

      // R5: all-ones at moderate length
      for (int i = 0; i < 4; i++) begin amem[i] = 16'hFFFF; bmem[i] = 16'hFFFF; end
      run_op(4, 1'b0, "R5 n=4 ones");

      // R3: mixed patterns
      for (int i = 0; i < 7; i++) begin
         amem[i] = (i % 2 == 0) ? 16'hAAAA : 16'h5555;
         bmem[i] = 16'(i * 16'h1111 + 1);
      end
      run_op(7, 1'b0, "R3 n=7 pattern");

      // R4: zero operand gives all-zero digits
      for (int i = 0; i < 5; i++) begin amem[i] = 16'h0000; bmem[i] = next_rand(); end
      run_op(5, 1'b0, "R4 n=5 zero");

      // R9: start pulse in the middle of a run
      for (int i = 0; i < 5; i++) begin amem[i] = next_rand(); bmem[i] = next_rand(); end
      run_op(5, 1'b1, "R9 n=5 busy start");

      // R5 / R6: full length all-ones
      for (int i = 0; i < MAXN; i++) begin amem[i] = 16'hFFFF; bmem[i] = 16'hFFFF; end
      run_op(MAXN, 1'b0, "R5 R6 n=32 ones");

      // R6: full length random
      for (int i = 0; i < MAXN; i++) begin amem[i] = next_rand(); bmem[i] = next_rand(); end
      run_op(MAXN, 1'b0, "R6 n=32 random");

      // R2: odd length with uneven digits
      for (int i = 0; i < 13; i++) begin amem[i] = next_rand(); bmem[i] = 16'hFFFF - 16'(i); end
      run_op(13, 1'b0, "R2 n=13 random");

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule